// File: doc/BRIEF.md
# ECC Check-Bit Fault Injector

This block sits in the write path of a memory controller that keeps a 7-bit ECC check code next to every stored data word. The normal ECC encoder hands it the check code for each outgoing word, and the block registers the word, the code and the write strobe on their way to the memory. Test and error-handler software can arm a one-shot override through an 8-bit control register. While the override is armed, the next memory write stores a pattern chosen by software in place of the generated code. The block then disarms itself, so software can poll the arm flag to learn whether the corrupted write has reached memory.

On the read side, the block takes the check code that was stored with a word and a code regenerated from the returned data. It raises a one-cycle error pulse when the two codes differ. This lets software confirm that an injected fault is detected on read-back.

The control byte is laid out as follows. Bit 7 is the arm flag. Bits 6 to 0 hold the forced pattern. Every register write replaces all eight bits.

Top module: `ecc_fault_injector`

## Requirements
- R1: After `rst_n` is asserted, or after a cycle with `sw_rst` high, `reg_rdata` reads 0x00. The hardware reset also clears `mem_wr_out` and `rd_err`.
- R2: `reg_rdata` always shows the control byte. Bit 7 is the arm flag, bits 6..0 are the forced pattern, and a register write takes effect on the following edge.
- R3: When the arm flag is 0 at the edge where `mem_wr_in` is sampled, `chk_out` equals `gen_chk_in` one cycle later. In the same cycle, `wr_data_out` equals `wr_data_in` and `mem_wr_out` is 1.
- R4: When the arm flag is 1 at the edge where `mem_wr_in` is sampled, `chk_out` one cycle later equals the forced pattern, whatever `gen_chk_in` is.
- R5: The arm flag clears in hardware on the edge that applies the pattern. Later memory writes store `gen_chk_in` again.
- R6: While armed and no memory write occurs, bit 7 of `reg_rdata` stays 1.
- R7: When a register write and a memory write land on the same edge, the register write decides the new control byte. The current memory write uses the flag and pattern held before that edge.
- R8: The forced pattern keeps its value after the flag self-clears. Writing the byte again with bit 7 set re-arms the same pattern.
- R9: `rd_err` is 1 in the cycle after `rd_valid` is high with `rd_chk_stored` different from `rd_chk_regen`. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset of the control byte |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control byte to write |
| reg_rdata | output | 8 | Current control byte |
| mem_wr_in | input | 1 | Memory write strobe from the controller |
| wr_data_in | input | DATA_W | Write data |
| gen_chk_in | input | 7 | Check code from the ECC encoder |
| mem_wr_out | output | 1 | Registered memory write strobe |
| wr_data_out | output | DATA_W | Registered write data |
| chk_out | output | 7 | Registered check code sent to memory |
| rd_valid | input | 1 | Read data valid strobe |
| rd_chk_stored | input | 7 | Check code read from memory |
| rd_chk_regen | input | 7 | Check code regenerated from read data |
| rd_err | output | 1 | One-cycle mismatch pulse |

## Verification
Some behaviour is checked on every cycle. This covers the choice between the generated code and the forced pattern, the self-clear of the arm flag, how long a pending arm is held, the precedence of a register write, software reset, and the mismatch pulse. Other behaviour only directed scenarios can show. These include the order of several operations in sequence: a pattern surviving the self-clear and being re-armed, and a collision whose injection lands on the following write rather than the current one. They also include full data-word pass-through across distinct values.

// File: rtl/ecc_fault_injector.sv
module ecc_fault_injector #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 7,
  localparam int REG_W = CHK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              mem_wr_in,
  input  logic [DATA_W-1:0] wr_data_in,
  input  logic [CHK_W-1:0]  gen_chk_in,
  output logic              mem_wr_out,
  output logic [DATA_W-1:0] wr_data_out,
  output logic [CHK_W-1:0]  chk_out,
  input  logic              rd_valid,
  input  logic [CHK_W-1:0]  rd_chk_stored,
  input  logic [CHK_W-1:0]  rd_chk_regen,
  output logic              rd_err
);

  logic             armed;
  logic [CHK_W-1:0] pattern;
  logic [CHK_W-1:0] chk_sel;

  assign reg_rdata = {armed, pattern};
  assign chk_sel   = armed ? pattern : gen_chk_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      pattern <= '0;
    end else if (sw_rst) begin
      armed   <= 1'b0;
      pattern <= '0;
    end else if (reg_we) begin
      armed   <= reg_wdata[REG_W-1];
      pattern <= reg_wdata[CHK_W-1:0];
    end else if (mem_wr_in && armed) begin
      armed   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_wr_out  <= 1'b0;
      wr_data_out <= '0;
      chk_out     <= '0;
    end else begin
      mem_wr_out <= mem_wr_in;
      if (mem_wr_in) begin
        wr_data_out <= wr_data_in;
        chk_out     <= chk_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_err <= 1'b0;
    else        rd_err <= rd_valid && (rd_chk_stored != rd_chk_regen);
  end

endmodule

// File: rtl/ecc_fault_injector_chk.sv
module ecc_fault_injector_chk #(
  parameter int CHK_W = 7,
  localparam int REG_W = CHK_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_rst,
  input logic             reg_we,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             mem_wr_in,
  input logic [CHK_W-1:0] gen_chk_in,
  input logic             mem_wr_out,
  input logic [CHK_W-1:0] chk_out,
  input logic             rd_valid,
  input logic [CHK_W-1:0] rd_chk_stored,
  input logic [CHK_W-1:0] rd_chk_regen,
  input logic             rd_err
);

  assert_sw_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> reg_rdata == '0);

  assert_reg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !sw_rst) |=> reg_rdata == $past(reg_wdata));

  assert_disarmed_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_in && !reg_rdata[REG_W-1]) |=> (mem_wr_out && chk_out == $past(gen_chk_in)));

  assert_armed_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_in && reg_rdata[REG_W-1]) |=> chk_out == $past(reg_rdata[CHK_W-1:0]));

  assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_in && !reg_we) |=> !reg_rdata[REG_W-1]);

  assert_pending_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[REG_W-1] && !mem_wr_in && !reg_we && !sw_rst) |=> reg_rdata[REG_W-1]);

  assert_reg_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && mem_wr_in && !sw_rst) |=> reg_rdata == $past(reg_wdata));

  assert_pattern_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !sw_rst) |=> $stable(reg_rdata[CHK_W-1:0]));

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_chk_stored != rd_chk_regen) |=> rd_err);

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_chk_stored != rd_chk_regen) |=> !rd_err);

endmodule

bind ecc_fault_injector ecc_fault_injector_chk #(.CHK_W(CHK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr_in(mem_wr_in),
  .gen_chk_in(gen_chk_in), .mem_wr_out(mem_wr_out), .chk_out(chk_out),
  .rd_valid(rd_valid), .rd_chk_stored(rd_chk_stored),
  .rd_chk_regen(rd_chk_regen), .rd_err(rd_err)
);

// File: tb/tb_ecc_fault_injector.sv
module tb_ecc_fault_injector;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sw_rst = 1'b0;
  logic              reg_we = 1'b0;
  logic [7:0]        reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic              mem_wr_in = 1'b0;
  logic [DATA_W-1:0] wr_data_in = '0;
  logic [CHK_W-1:0]  gen_chk_in = '0;
  logic              mem_wr_out;
  logic [DATA_W-1:0] wr_data_out;
  logic [CHK_W-1:0]  chk_out;
  logic              rd_valid = 1'b0;
  logic [CHK_W-1:0]  rd_chk_stored = '0;
  logic [CHK_W-1:0]  rd_chk_regen = '0;
  logic              rd_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ecc_fault_injector #(.DATA_W(DATA_W), .CHK_W(CHK_W)) dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr_in(mem_wr_in),
    .wr_data_in(wr_data_in), .gen_chk_in(gen_chk_in), .mem_wr_out(mem_wr_out),
    .wr_data_out(wr_data_out), .chk_out(chk_out), .rd_valid(rd_valid),
    .rd_chk_stored(rd_chk_stored), .rd_chk_regen(rd_chk_regen), .rd_err(rd_err)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    reg_we = 0; mem_wr_in = 0; sw_rst = 0; rd_valid = 0;
  endtask

  task automatic reg_write(logic [7:0] v);
    idle(); reg_we = 1; reg_wdata = v;
    step();
    idle();
  endtask

  task automatic mem_write(logic [DATA_W-1:0] d, logic [CHK_W-1:0] g);
    idle(); mem_wr_in = 1; wr_data_in = d; gen_chk_in = g;
    step();
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (2) step();
    check("R1 reg after reset", reg_rdata, 8'h00);
    check("R1 mem_wr_out after reset", mem_wr_out, 1'b0);
    check("R1 rd_err after reset", rd_err, 1'b0);
    idle(); rst_n = 1; step();
  endtask

  task automatic t_disarmed();
    reg_write(8'h2A);
    check("R2 readback", reg_rdata, 8'h2A);
    mem_write(32'hDEAD_BEEF, 7'h11);
    check("R3 chk passes", chk_out, 7'h11);
    check("R3 data", wr_data_out, 32'hDEAD_BEEF);
    check("R3 strobe", mem_wr_out, 1'b1);
    idle(); step();
    check("R3 strobe drops", mem_wr_out, 1'b0);
  endtask

  task automatic t_inject();
    reg_write(8'hD5);
    check("R2 armed readback", reg_rdata, 8'hD5);
    repeat (3) step();
    check("R6 still pending", reg_rdata[7], 1'b1);
    mem_write(32'h1234_5678, 7'h0F);
    check("R4 forced pattern", chk_out, 7'h55);
    check("R5 flag cleared", reg_rdata[7], 1'b0);
    check("R8 pattern kept", reg_rdata[6:0], 7'h55);
    mem_write(32'h0000_0001, 7'h0F);
    check("R5 back to generated", chk_out, 7'h0F);
    idle();
  endtask

  task automatic t_collision();
    idle();
    reg_we = 1; reg_wdata = 8'hB3;
    mem_wr_in = 1; wr_data_in = 32'hA5A5_A5A5; gen_chk_in = 7'h01;
    step();
    check("R7 current write unforced", chk_out, 7'h01);
    check("R7 register write wins", reg_rdata, 8'hB3);
    mem_write(32'h5A5A_5A5A, 7'h02);
    check("R7 next write forced", chk_out, 7'h33);
    check("R5 cleared after collision", reg_rdata, 8'h33);
    idle();
  endtask

  task automatic t_rearm();
    reg_write({1'b1, reg_rdata[6:0]});
    check("R8 re-armed", reg_rdata, 8'hB3);
    mem_write(32'h0F0F_0F0F, 7'h7E);
    check("R8 same pattern applied", chk_out, 7'h33);
    idle();
  endtask

  task automatic t_swrst();
    reg_write(8'hFF);
    idle(); sw_rst = 1; step();
    idle();
    check("R1 software reset", reg_rdata, 8'h00);
    mem_write(32'hCAFE_0000, 7'h22);
    check("R1 no injection after reset", chk_out, 7'h22);
    idle();
  endtask

  task automatic t_read();
    idle(); rd_valid = 1; rd_chk_stored = 7'h15; rd_chk_regen = 7'h15; step();
    check("R9 equal codes", rd_err, 1'b0);
    idle(); rd_valid = 1; rd_chk_regen = 7'h14; step();
    check("R9 mismatch pulse", rd_err, 1'b1);
    idle(); step();
    check("R9 single cycle", rd_err, 1'b0);
    idle(); rd_valid = 0; rd_chk_regen = 7'h00; step();
    check("R9 not valid", rd_err, 1'b0);
  endtask

  initial begin
    t_reset();
    t_disarmed();
    t_inject();
    t_collision();
    t_rearm();
    t_swrst();
    t_read();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule